// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps an SDRAM's contents alive while an access engine uses the memory. A free-running interval timer adds one pending refresh each period. The pending count is the refresh debt. When the access engine says it is idle, the scheduler takes the command bus. It closes every open row with a precharge-all command, then issues auto-refresh commands spaced by the refresh cycle time until the debt is cleared. The engine may postpone refreshes up to a set limit. When the debt reaches that limit, the scheduler demands the bus at once and holds the engine off until it is idle.

The block also drives the SDRAM power-up sequence: a wait with no-ops, then a precharge-all, two auto refreshes and a mode register write. It also handles low-power self-refresh. While a self-refresh request is held, the scheduler closes all rows and enters self-refresh by issuing the refresh encoding with the clock enable dropped in the same cycle. When the request is released, it raises the clock enable with no-ops on the command pins. It then keeps the engine off the bus for one refresh cycle time.

Timings are given in clock cycles. The interval reload defaults to 15.625 µs times the clock rate in MHz, which meets a budget of 4096 refreshes in 64 ms.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset the pins show NOP for T_INIT_CYC cycles. Then come a precharge-all, an auto refresh T_RP_CYC later, a second auto refresh T_RFC_CYC after that, and a mode register write T_RFC_CYC after that, with MODE_WORD on the address. `busy` stays high until T_MRD_CYC cycles after the mode write.
- R2: Once the power-up sequence is complete, the pending count rises by exactly one every REF_INTERVAL cycles while no refresh is issued.
- R3: `ref_pending` never exceeds MAX_DEBT. At MAX_DEBT further interval expiries are dropped, and the count stays at MAX_DEBT.
- R4: Commands other than NOP appear only while `busy` is high. `busy` rises below the debt limit only in the cycle after one in which `eng_idle` was high.
- R5: A precharge-all has A10 (address bit 10) high. Every refresh-encoded command comes exactly T_RP_CYC after a precharge-all or exactly T_RFC_CYC after another refresh-encoded command.
- R6: After an auto refresh, no command other than NOP is issued for T_RFC_CYC-1 cycles. Pending refreshes are issued back to back. `busy` falls exactly T_RFC_CYC cycles after the last one.
- R7: While `ref_pending` equals MAX_DEBT, `busy` is high even if `eng_idle` is low. No command is issued until `eng_idle` is seen, and the precharge-all follows one cycle after that.
- R8: While `sr_req` is high, the block precharges all banks and then issues the refresh encoding with `sd_cke` low in that same cycle. `sd_cke` falls only with that encoding. The pending count is cleared, and `busy` and a low `sd_cke` are held while the request stays high.
- R9: When `sr_req` drops, `sd_cke` is high in the next cycle with NOP on the pins. `busy` stays high for exactly T_RFC_CYC cycles starting with that cycle.
- R10: Interval expiries during power-up and self-refresh add no debt.
- R11: Command encodings are given as (CS#, RAS#, CAS#, WE#): NOP 0111, precharge 0010, refresh 0001, mode write 0000. An auto refresh has `sd_cke` high in both the previous and the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_idle | input | 1 | Access engine issues nothing this cycle or next |
| sr_req | input | 1 | Level request to hold the memory in self-refresh |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins (A10 or mode word) |
| busy | output | 1 | Scheduler owns the bus; the engine must stay off |
| ref_pending | output | $clog2(MAX_DEBT+1) | Refreshes owed |

## Verification
The refresh path is driven in three ways. In the first, the engine stays busy until the debt saturates; this separates correct interval accrual and saturation from lost or extra ticks, and shows that forced priority still waits for idle. In the second, a single idle grant drains all of the accumulated debt; this checks back-to-back spacing and the exact release cycle. In the third, seeded random idle patterns with occasional self-refresh requests exercise entry from every state. A running monitor checks command spacing, the A10 flag, CKE edges and grant timing in every cycle. Directed entry and exit of self-refresh pin down the cycle in which CKE falls and rises and the recovery window.

// File: rtl/sdram_refsched_pkg.sv
package sdram_refsched_pkg;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sd_cmd_t;

   localparam sd_cmd_t CMD_NOP = 4'b0111;
   localparam sd_cmd_t CMD_PRE = 4'b0010;
   localparam sd_cmd_t CMD_REF = 4'b0001;
   localparam sd_cmd_t CMD_MRS = 4'b0000;

   typedef enum logic [4:0] {
      S_PWR_WAIT, S_PWR_PRE, S_PWR_RP, S_PWR_REF1, S_PWR_RFC1,
      S_PWR_REF2, S_PWR_RFC2, S_PWR_MRS, S_PWR_MRD,
      S_IDLE, S_PRE, S_RP, S_REF, S_RFC,
      S_SR_IN, S_SR_HOLD, S_SR_OUT
   } seq_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
   parameter int INTERVAL = 2234
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int INT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

   generate
      if (INTERVAL < 2) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         logic [INT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || cnt_q == '0) cnt_q <= INT_W'(INTERVAL - 1);
            else                       cnt_q <= cnt_q - 1'b1;
         end
         assign tick = (cnt_q == '0);

         // R2
         tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
   parameter int MAX_DEBT = 8,
   parameter int W        = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   input  logic         clr,
   output logic [W-1:0] debt,
   output logic         nz,
   output logic         full
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) debt <= '0;
      else if (inc && !dec && !full) debt <= debt + 1'b1;
      else if (dec && !inc && nz)    debt <= debt - 1'b1;
   end

   assign nz   = (debt != '0);
   assign full = (debt == W'(MAX_DEBT));

   // R3
   debt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      debt <= W'(MAX_DEBT));

   // R3
   debt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (debt != $past(debt)) |->
         (debt == $past(debt) + 1'b1 || debt + 1'b1 == $past(debt) || debt == '0));
endmodule

// File: rtl/refsched_seq.sv
module refsched_seq
   import sdram_refsched_pkg::*;
#(
   parameter int T_INIT_CYC = 28600,
   parameter int T_RP_CYC   = 3,
   parameter int T_RFC_CYC  = 9,
   parameter int T_MRD_CYC  = 2,
   parameter int ADDR_W     = 12,
   parameter int A10_BIT    = 10,
   parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_idle,
   input  logic              sr_req,
   input  logic              debt_nz,
   input  logic              debt_full,
   output sd_cmd_t           cmd,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cke,
   output logic              busy,
   output logic              accrue_en,
   output logic              ref_issue,
   output logic              debt_clr
);
   localparam int CNT_MAX = imax(imax(T_INIT_CYC, T_RFC_CYC), imax(T_RP_CYC, T_MRD_CYC));
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   seq_state_e       st, nxt;
   logic [CNT_W-1:0] cnt_q, ld_val;
   logic             ld, cnt_done;

   assign cnt_done = (cnt_q == '0);

   always_comb begin
      nxt    = st;
      ld     = 1'b0;
      ld_val = '0;
      case (st)
         S_PWR_WAIT: if (cnt_done) nxt = S_PWR_PRE;
         S_PWR_PRE:  begin nxt = S_PWR_RP;   ld = 1'b1; ld_val = CNT_W'(T_RP_CYC - 2);  end
         S_PWR_RP:   if (cnt_done) nxt = S_PWR_REF1;
         S_PWR_REF1: begin nxt = S_PWR_RFC1; ld = 1'b1; ld_val = CNT_W'(T_RFC_CYC - 2); end
         S_PWR_RFC1: if (cnt_done) nxt = S_PWR_REF2;
         S_PWR_REF2: begin nxt = S_PWR_RFC2; ld = 1'b1; ld_val = CNT_W'(T_RFC_CYC - 2); end
         S_PWR_RFC2: if (cnt_done) nxt = S_PWR_MRS;
         S_PWR_MRS:  begin nxt = S_PWR_MRD;  ld = 1'b1; ld_val = CNT_W'(T_MRD_CYC - 2); end
         S_PWR_MRD:  if (cnt_done) nxt = S_IDLE;
         S_IDLE:     if ((sr_req || debt_nz) && eng_idle) nxt = S_PRE;
         S_PRE:      begin nxt = S_RP; ld = 1'b1; ld_val = CNT_W'(T_RP_CYC - 2); end
         S_REF:      begin nxt = S_RFC; ld = 1'b1; ld_val = CNT_W'(T_RFC_CYC - 2); end
         S_RP, S_RFC: if (cnt_done) begin
            if (sr_req)       nxt = S_SR_IN;
            else if (debt_nz) nxt = S_REF;
            else              nxt = S_IDLE;
         end
         S_SR_IN:    nxt = S_SR_HOLD;
         S_SR_HOLD:  if (!sr_req) begin
            nxt = S_SR_OUT; ld = 1'b1; ld_val = CNT_W'(T_RFC_CYC - 1);
         end
         S_SR_OUT:   if (cnt_done) nxt = S_IDLE;
         default:    nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= S_PWR_WAIT;
         cnt_q <= CNT_W'(T_INIT_CYC - 1);
      end else begin
         st <= nxt;
         if (ld)            cnt_q <= ld_val;
         else if (!cnt_done) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      cmd      = CMD_NOP;
      cmd_addr = '0;
      case (st)
         S_PWR_PRE, S_PRE: begin cmd = CMD_PRE; cmd_addr[A10_BIT] = 1'b1; end
         S_PWR_REF1, S_PWR_REF2, S_REF, S_SR_IN: cmd = CMD_REF;
         S_PWR_MRS: begin cmd = CMD_MRS; cmd_addr = MODE_WORD; end
         default: ;
      endcase
   end

   assign cke       = !(st == S_SR_IN || st == S_SR_HOLD);
   assign busy      = (st != S_IDLE) || debt_full;
   assign ref_issue = (st == S_REF);
   assign debt_clr  = (st == S_SR_IN) || (st == S_PWR_MRS);
   assign accrue_en = (st >= S_IDLE) && (st <= S_RFC);

   // R4
   grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && !debt_full) |-> $past(eng_idle));
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
   import sdram_refsched_pkg::*;
#(
   parameter int CLK_MHZ      = 143,
   parameter int REF_INTERVAL = CLK_MHZ * 15625 / 1000,
   parameter int T_INIT_CYC   = CLK_MHZ * 200,
   parameter int T_RP_CYC     = 3,
   parameter int T_RFC_CYC    = 9,
   parameter int T_MRD_CYC    = 2,
   parameter int MAX_DEBT     = 8,
   parameter int ADDR_W       = 12,
   parameter logic [ADDR_W-1:0] MODE_WORD = 12'h032,
   localparam int DEBT_W      = $clog2(MAX_DEBT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_idle,
   input  logic              sr_req,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [ADDR_W-1:0] sd_addr,
   output logic              busy,
   output logic [DEBT_W-1:0] ref_pending
);
   localparam int A10_BIT = 10;

   generate
      if (T_RP_CYC < 2 || T_RFC_CYC < 2 || T_MRD_CYC < 2) begin : g_bad_timing
         $error("command spacings must be at least two cycles");
      end
      if (ADDR_W <= A10_BIT) begin : g_bad_addr
         $error("address bus too narrow for the all-banks flag");
      end
      if (MAX_DEBT < 1 || T_INIT_CYC < 1 || REF_INTERVAL < 1) begin : g_bad_count
         $error("debt limit, power-up wait and interval must be positive");
      end
   endgenerate

   sd_cmd_t cmd;
   logic    tick, accrue_en, ref_issue, debt_clr, debt_nz, debt_full;

   refsched_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   refsched_debt #(.MAX_DEBT(MAX_DEBT), .W(DEBT_W)) u_debt (
      .clk(clk), .rst_n(rst_n), .inc(tick && accrue_en), .dec(ref_issue),
      .clr(debt_clr), .debt(ref_pending), .nz(debt_nz), .full(debt_full));

   refsched_seq #(
      .T_INIT_CYC(T_INIT_CYC), .T_RP_CYC(T_RP_CYC), .T_RFC_CYC(T_RFC_CYC),
      .T_MRD_CYC(T_MRD_CYC), .ADDR_W(ADDR_W), .A10_BIT(A10_BIT), .MODE_WORD(MODE_WORD)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .eng_idle(eng_idle), .sr_req(sr_req),
      .debt_nz(debt_nz), .debt_full(debt_full), .cmd(cmd), .cmd_addr(sd_addr),
      .cke(sd_cke), .busy(busy), .accrue_en(accrue_en), .ref_issue(ref_issue),
      .debt_clr(debt_clr));

   assign sd_cs_n  = cmd.cs_n;
   assign sd_ras_n = cmd.ras_n;
   assign sd_cas_n = cmd.cas_n;
   assign sd_we_n  = cmd.we_n;

   logic pin_ref, pin_pre, pin_nop;
   assign pin_ref = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001);
   assign pin_pre = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010);
   assign pin_nop = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111);

   // R6
   ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_ref && sd_cke) |=> pin_nop);

   // R5
   pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_pre |-> sd_addr[A10_BIT]);

   // R8
   cke_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sd_cke) |-> pin_ref);

   // R11
   auto_ref_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_ref && sd_cke) |-> $past(sd_cke));

   // R7
   full_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pending == DEBT_W'(MAX_DEBT)) |-> busy);
endmodule

// File: tb/sdram_refresh_sched_test.sv
module sdram_refresh_sched_test;
   localparam int CLK_PERIOD = 10;
   localparam int P_INTERVAL = 40;
   localparam int P_INIT     = 20;
   localparam int P_RP       = 3;
   localparam int P_RFC      = 6;
   localparam int P_MRD      = 2;
   localparam int P_MAX      = 8;
   localparam logic [11:0] P_MODE = 12'h027;
   localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

   logic clk = 0, rst_n = 0, eng_idle = 0, sr_req = 0;
   logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, busy;
   logic [11:0] sd_addr;
   logic [3:0]  ref_pending;

   sdram_refresh_sched #(
      .REF_INTERVAL(P_INTERVAL), .T_INIT_CYC(P_INIT), .T_RP_CYC(P_RP),
      .T_RFC_CYC(P_RFC), .T_MRD_CYC(P_MRD), .MAX_DEBT(P_MAX), .ADDR_W(12),
      .MODE_WORD(P_MODE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .eng_idle(eng_idle), .sr_req(sr_req),
      .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
      .sd_we_n(sd_we_n), .sd_addr(sd_addr), .busy(busy), .ref_pending(ref_pending));

   always #(CLK_PERIOD/2) clk = ~clk;

   int nchk = 0, nerr = 0, cyc = 0;
   bit done = 0;

   always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   endtask

   function automatic int exp_gap(input logic [3:0] prev);
      return (prev == C_PRE) ? P_RP : P_RFC;
   endfunction

   function automatic int init_cycle(input int k);
      return (k == 0) ? P_INIT : P_INIT + P_RP + (k - 1) * P_RFC;
   endfunction

   function automatic logic [3:0] init_cmd(input int k);
      return (k == 0) ? C_PRE : (k == 3) ? C_MRS : C_REF;
   endfunction

   // running monitor
   logic [3:0] mcmd, last_cmd;
   int last_cyc = 0, last_ref_cyc = 0, ic = 0, ninc = 0, ncmds = 0, nrefs = 0;
   bit have_cmd = 0, have_ref = 0, rec_inc = 0;
   bit prev_cke = 1, prev_busy = 1, prev_idle = 0;
   int prev_debt = 0;
   logic [3:0] init_c [4];
   int init_t [4];
   logic [11:0] mrs_addr;
   int inc_cyc [16];

   always @(negedge clk) begin
      if (rst_n && !done) begin
         mcmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
         if (mcmd != C_NOP) begin
            check(busy, "R4", "command while busy low", busy, 1);
            if (mcmd == C_PRE) check(sd_addr[10], "R5", "precharge A10", sd_addr[10], 1);
            if (have_ref)
               check(cyc - last_ref_cyc >= P_RFC, "R6", "cycles since refresh",
                     cyc - last_ref_cyc, P_RFC);
            if (mcmd == C_REF && have_cmd)
               check((last_cmd == C_PRE || last_cmd == C_REF) &&
                     (cyc - last_cyc == exp_gap(last_cmd)), "R5", "spacing before refresh",
                     cyc - last_cyc, exp_gap(last_cmd));
            if (ic < 4) begin
               init_c[ic] = mcmd; init_t[ic] = cyc;
               if (mcmd == C_MRS) mrs_addr = sd_addr;
               ic++;
            end
            ncmds++;
            if (mcmd == C_REF) begin nrefs++; last_ref_cyc = cyc; have_ref = 1; end
            last_cmd = mcmd; last_cyc = cyc; have_cmd = 1;
         end
         if (prev_cke && !sd_cke) check(mcmd == C_REF, "R8", "cke fall encoding", mcmd, C_REF);
         if (busy && !prev_busy && ref_pending != P_MAX)
            check(prev_idle, "R4", "grant without idle", prev_idle, 1);
         if (ref_pending == P_MAX) check(busy, "R7", "busy at debt limit", busy, 1);
         if (rec_inc && int'(ref_pending) == prev_debt + 1 && ninc < 16) begin
            inc_cyc[ninc] = cyc; ninc++;
         end
         prev_cke = sd_cke; prev_busy = busy; prev_idle = eng_idle; prev_debt = ref_pending;
      end
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic drive(input bit idle, input bit sr);
      @(posedge clk); #2;
      eng_idle = idle; sr_req = sr;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: run did not complete");
      finish_up();
   end

   initial begin
      int t0, s;
      void'($urandom(32'd20240611));
      repeat (3) step();
      // R1 reset state
      check(sd_cke, "R1", "cke in reset", sd_cke, 1);
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R11", "NOP in reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
      check(busy, "R1", "busy in reset", busy, 1);
      check(ref_pending == 0, "R1", "debt in reset", ref_pending, 0);
      @(posedge clk); #2; rst_n = 1;

      // R1 power-up sequence
      for (int i = 0; i < 500 && busy; i++) step();
      check(ic == 4, "R1", "power-up command count", ic, 4);
      for (int k = 0; k < 4; k++) begin
         check(init_c[k] == init_cmd(k), "R1", "power-up command", init_c[k], init_cmd(k));
         check(init_t[k] == init_cycle(k), "R1", "power-up timing", init_t[k], init_cycle(k));
      end
      check(mrs_addr == P_MODE, "R1", "mode word", mrs_addr, P_MODE);
      check(cyc == init_t[3] + P_MRD, "R1", "busy release after mode write", cyc, init_t[3] + P_MRD);
      rec_inc = 1; ncmds = 0;

      // R2 / R3 / R7: engine never idle, debt saturates
      for (int i = 0; i < 1000 && ref_pending != P_MAX; i++) step();
      rec_inc = 0;
      check(ninc == P_MAX, "R3", "increments to limit", ninc, P_MAX);
      for (int k = 1; k < ninc; k++)
         check(inc_cyc[k] - inc_cyc[k-1] == P_INTERVAL, "R2", "interval spacing",
               inc_cyc[k] - inc_cyc[k-1], P_INTERVAL);
      repeat (2 * P_INTERVAL + 5) step();
      check(ref_pending == P_MAX, "R3", "saturated debt", ref_pending, P_MAX);
      check(busy, "R7", "busy held at limit", busy, 1);
      check(ncmds == 0, "R7", "commands while engine busy", ncmds, 0);

      // R6 / R7: one grant drains the debt
      drive(1, 0); t0 = cyc; nrefs = 0;
      for (int i = 0; i < 50 && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP; i++) step();
      check(cyc == t0 + 1, "R7", "precharge after idle", cyc, t0 + 1);
      for (int i = 0; i < 500 && busy; i++) step();
      check(cyc == last_ref_cyc + P_RFC, "R6", "busy fall after last refresh", cyc, last_ref_cyc + P_RFC);
      check(nrefs >= P_MAX, "R6", "refreshes in drain", nrefs, P_MAX);
      check(ref_pending <= 1, "R6", "debt after drain", ref_pending, 0);

      // R8 / R10 / R9: self-refresh
      drive(1, 1);
      for (int i = 0; i < 200 && sd_cke; i++) step();
      check(!sd_cke, "R8", "cke low in self-refresh", sd_cke, 0);
      step();
      check(ref_pending == 0, "R8", "debt cleared at entry", ref_pending, 0);
      drive(0, 1);
      repeat (3 * P_INTERVAL) step();
      check(!sd_cke, "R8", "cke held low", sd_cke, 0);
      check(busy, "R8", "busy in self-refresh", busy, 1);
      check(ref_pending == 0, "R10", "no accrual in self-refresh", ref_pending, 0);
      drive(0, 0); s = cyc;
      step();
      check(!sd_cke, "R9", "cke before exit edge", sd_cke, 0);
      step();
      check(sd_cke && cyc == s + 1, "R9", "cke raised", sd_cke, 1);
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R9", "NOP at exit",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
      for (int i = 0; i < 100 && busy; i++) step();
      check(cyc == s + 1 + P_RFC, "R9", "recovery window", cyc, s + 1 + P_RFC);

      // random traffic with occasional self-refresh
      for (int i = 0; i < 4000; i++) begin
         bit sr_n = sr_req;
         if ($urandom_range(0, 299) == 0) sr_n = !sr_req;
         drive($urandom_range(0, 3) != 0, sr_n);
      end
      drive(1, 0);
      s = 0;
      for (int i = 0; i < 300; i++) begin step(); if (!busy) s++; end
      check(s > 0, "R4", "bus returned to engine", s, 1);

      finish_up();
   end
endmodule